// File: doc/BRIEF.md
# Flash Reprogramming Control Register

This block is an 8-bit control and status register that sits between a CPU bus and an on-chip flash sequencer. Software reaches it with byte writes and reads at one bus address. It drives four outputs into the flash subsystem:

- a reprogramming-mode enable;
- an instruction-fetch inhibit for the internal flash, which follows the mode enable;
- a flash-circuit reset;
- a boot/user area select.

It also keeps a ready/busy flag. The flag follows the sequencer's busy line, but only while the sequencer reports a program, block-erase or erase-all command.

The mode enable is guarded by an arming state machine. Its three states are:

- `ARM_IDLE`: the mode is off and not armed.
- `ARM_PRIMED`: the mode is off, and a register write with bit 1 = 0 has been seen.
- `ARM_ON`: the mode is on.

Its transitions are:

- *prime*: `ARM_IDLE` to `ARM_PRIMED`, on a register write with bit 1 = 0.
- *re-prime*: `ARM_PRIMED` to `ARM_PRIMED`, on another register write with bit 1 = 0.
- *cancel*: `ARM_PRIMED` to `ARM_IDLE`, on a write to any other address.
- *enter*: `ARM_PRIMED` to `ARM_ON`, on a register write with bit 1 = 1.
- *exit*: `ARM_ON` to `ARM_PRIMED`, on a register write with bit 1 = 0. This write also counts as the first half of a new pair.

A register write with bit 1 = 1 in `ARM_IDLE` is refused, and the state machine stays in `ARM_IDLE`.

The ready tracker is a second state machine with two states, `TRK_READY` and `TRK_BUSY`. Its transitions are:

- *start*: `TRK_READY` to `TRK_BUSY`, when busy is high with a qualifying command.
- *finish*: `TRK_BUSY` to `TRK_READY`, when busy is low with a qualifying command.

With any other command code it holds its state.

Register layout, for reads and writes:

| Bit | Access | Meaning |
|-----|--------|---------|
| 0 | read only | ready flag (1 = ready) |
| 1 | read/write | mode enable |
| 3 | read/write | flash reset |
| 5 | read/write | area select (1 = user area, 0 = boot area) |
| 2, 4, 6, 7 | read only | always read 0 |

Top module: `flash_ctl_reg`

## Requirements
- R1: Bit 0 (the ready flag) is 0 while the sequencer is busy and 1 once it is idle. It updates one clock after `seq_busy`, and only while `seq_cmd` is 1 (program), 2 (block erase) or 3 (erase all). With any other command code it holds its value.
- R2: A single register write with bit 1 = 1, made from `ARM_IDLE`, leaves the mode enable at 0.
- R3: Two consecutive register writes, the first with bit 1 = 0 and the second with bit 1 = 1, set the mode enable one clock after the second write.
- R4: A register write with bit 1 = 0 clears the mode enable on the clock of that write.
- R5: `fetch_inhibit` equals the mode enable (bit 1) at all times.
- R6: Bit 3 (flash reset) takes the written value only when the mode enable is already 1 and the write keeps bit 1 = 1. A write of bit 3 while the mode enable is 0 is ignored, and bit 3 stays 0.
- R7: Whenever the mode enable goes to 0, bit 3 goes to 0 on the same clock. `flash_rst` is never 1 while the mode enable is 0.
- R8: After reset the register reads 0x01. Bits 2, 4, 6 and 7 always read 0.
- R9: A write to any other address between the two arming writes cancels the sequence, so a following bit-1 = 1 write does not set the mode.
- R10: Bit 5 (area select) is written only while `boot_mode` is 1. While `boot_mode` is 0 a write leaves it unchanged. `area_user` equals bit 5.
- R11: `rd_data` is 0 whenever `bus_addr` is not the register address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_wr | input | 1 | write strobe, one clock per write |
| bus_addr | input | ADDR_W | bus address |
| bus_wdata | input | 8 | write data |
| rd_data | output | 8 | read data (register value when the address matches, else 0) |
| seq_busy | input | 1 | sequencer busy |
| seq_cmd | input | CMD_W | command type currently running in the sequencer |
| boot_mode | input | 1 | high when the chip runs in boot mode |
| rpm_en | output | 1 | reprogramming-mode enable |
| fetch_inhibit | output | 1 | blocks instruction fetch from the internal flash |
| flash_rst | output | 1 | flash-circuit reset |
| area_user | output | 1 | 1 selects the user area, 0 selects the boot area |

## Verification
The bench builds the block with its default parameters: an 8-bit address, register address 0x40 and a 3-bit command code. With these values, writes to address 0x41 exercise the cancel path. Command code 4 serves as the non-qualifying command that must leave the ready flag alone. The default command codes 1, 2 and 3 bring each qualifying command type within reach.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_RDY  = 0;
    localparam int unsigned BIT_MODE = 1;
    localparam int unsigned BIT_FRST = 3;
    localparam int unsigned BIT_AREA = 5;

    typedef enum logic [1:0] {
        ARM_IDLE   = 2'd0,
        ARM_PRIMED = 2'd1,
        ARM_ON     = 2'd2
    } arm_state_t;

    typedef enum logic {
        TRK_READY = 1'b0,
        TRK_BUSY  = 1'b1
    } trk_state_t;

endpackage

// File: rtl/fcr_arm_fsm.sv
module fcr_arm_fsm
    import flash_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_other,
    input  logic wr_mode_bit,
    output logic mode_on
);

    arm_state_t state_q;
    arm_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: begin
                // prime
                if (wr_hit && !wr_mode_bit) begin
                    state_d = ARM_PRIMED;
                end
            end
            ARM_PRIMED: begin
                if (wr_hit) begin
                    // enter, or re-prime
                    state_d = wr_mode_bit ? ARM_ON : ARM_PRIMED;
                end else if (wr_other) begin
                    // cancel
                    state_d = ARM_IDLE;
                end
            end
            ARM_ON: begin
                // exit
                if (wr_hit && !wr_mode_bit) begin
                    state_d = ARM_PRIMED;
                end
            end
            default: state_d = ARM_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mode_on = (state_q == ARM_ON);
    end

endmodule

// File: rtl/fcr_ready_fsm.sv
module fcr_ready_fsm
    import flash_ctl_pkg::*;
#(
    parameter int unsigned    CMD_W     = 3,
    parameter logic [CMD_W-1:0] CMD_PROG  = 3'd1,
    parameter logic [CMD_W-1:0] CMD_BLK   = 3'd2,
    parameter logic [CMD_W-1:0] CMD_ALL   = 3'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_busy,
    input  logic [CMD_W-1:0] seq_cmd,
    output logic             ready
);

    trk_state_t state_q;
    trk_state_t state_d;
    logic       qual;

    always_comb begin
        qual = (seq_cmd == CMD_PROG) || (seq_cmd == CMD_BLK) || (seq_cmd == CMD_ALL);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_READY: begin
                // start
                if (qual && seq_busy) begin
                    state_d = TRK_BUSY;
                end
            end
            TRK_BUSY: begin
                // finish
                if (qual && !seq_busy) begin
                    state_d = TRK_READY;
                end
            end
            default: state_d = TRK_READY;
        endcase
    end

    // Outputs
    always_comb begin
        ready = (state_q == TRK_READY);
    end

endmodule

// File: rtl/fcr_ctl_bits.sv
module fcr_ctl_bits
    import flash_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             mode_on,
    input  logic             boot_mode,
    output logic             frst_bit,
    output logic             area_bit
);

    // Flash reset bit: written only while the mode is on and the write keeps it on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frst_bit <= 1'b0;
        end else if (wr_hit) begin
            if (mode_on && wdata[BIT_MODE]) begin
                frst_bit <= wdata[BIT_FRST];
            end else begin
                frst_bit <= 1'b0;
            end
        end else if (!mode_on) begin
            frst_bit <= 1'b0;
        end
    end

    // Area select: only writable in boot mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            area_bit <= 1'b0;
        end else if (wr_hit && boot_mode) begin
            area_bit <= wdata[BIT_AREA];
        end
    end

endmodule

// File: rtl/fcr_readback.sv
module fcr_readback
    import flash_ctl_pkg::*;
(
    input  logic             sel,
    input  logic             ready,
    input  logic             mode_on,
    input  logic             frst_bit,
    input  logic             area_bit,
    output logic [REG_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        if (sel) begin
            rd_data[BIT_RDY]  = ready;
            rd_data[BIT_MODE] = mode_on;
            rd_data[BIT_FRST] = frst_bit;
            rd_data[BIT_AREA] = area_bit;
        end
    end

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
    import flash_ctl_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40,
    parameter int unsigned      CMD_W    = 3,
    parameter logic [CMD_W-1:0] CMD_PROG = 3'd1,
    parameter logic [CMD_W-1:0] CMD_BLK  = 3'd2,
    parameter logic [CMD_W-1:0] CMD_ALL  = 3'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  rd_data,
    input  logic              seq_busy,
    input  logic [CMD_W-1:0]  seq_cmd,
    input  logic              boot_mode,
    output logic              rpm_en,
    output logic              fetch_inhibit,
    output logic              flash_rst,
    output logic              area_user
);

    logic addr_sel;
    logic wr_hit;
    logic wr_other;
    logic mode_on;
    logic ready;
    logic frst_bit;
    logic area_bit;

    always_comb begin
        addr_sel = (bus_addr == REG_ADDR);
        wr_hit   = bus_wr && addr_sel;
        wr_other = bus_wr && !addr_sel;
    end

    fcr_arm_fsm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (wr_hit),
        .wr_other    (wr_other),
        .wr_mode_bit (bus_wdata[BIT_MODE]),
        .mode_on     (mode_on)
    );

    fcr_ready_fsm #(
        .CMD_W    (CMD_W),
        .CMD_PROG (CMD_PROG),
        .CMD_BLK  (CMD_BLK),
        .CMD_ALL  (CMD_ALL)
    ) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_busy (seq_busy),
        .seq_cmd  (seq_cmd),
        .ready    (ready)
    );

    fcr_ctl_bits u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wdata     (bus_wdata),
        .mode_on   (mode_on),
        .boot_mode (boot_mode),
        .frst_bit  (frst_bit),
        .area_bit  (area_bit)
    );

    fcr_readback u_rb (
        .sel      (addr_sel),
        .ready    (ready),
        .mode_on  (mode_on),
        .frst_bit (frst_bit),
        .area_bit (area_bit),
        .rd_data  (rd_data)
    );

    always_comb begin
        rpm_en        = mode_on;
        fetch_inhibit = mode_on;
        flash_rst     = frst_bit;
        area_user     = area_bit;
    end

endmodule

// File: rtl/flash_ctl_reg_chk.sv
module flash_ctl_reg_chk #(
    parameter int unsigned CMD_W = 3,
    parameter logic [CMD_W-1:0] CMD_PROG = 3'd1,
    parameter logic [CMD_W-1:0] CMD_BLK  = 3'd2,
    parameter logic [CMD_W-1:0] CMD_ALL  = 3'd3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_hit,
    input logic [7:0]       bus_wdata,
    input logic [CMD_W-1:0] seq_cmd,
    input logic             boot_mode,
    input logic             ready,
    input logic             rpm_en,
    input logic             flash_rst,
    input logic             area_user
);

    logic qual;
    always_comb begin
        qual = (seq_cmd == CMD_PROG) || (seq_cmd == CMD_BLK) || (seq_cmd == CMD_ALL);
    end

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> $stable(ready));

    // R3
    mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rpm_en) |-> $past(wr_hit && bus_wdata[1]));

    // R4
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !bus_wdata[1]) |=> !rpm_en);

    // R6
    frst_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !rpm_en) |=> !flash_rst);

    // R7
    frst_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rst |-> rpm_en);

    // R10
    area_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !boot_mode) |=> $stable(area_user));

endmodule

bind flash_ctl_reg flash_ctl_reg_chk #(
    .CMD_W    (CMD_W),
    .CMD_PROG (CMD_PROG),
    .CMD_BLK  (CMD_BLK),
    .CMD_ALL  (CMD_ALL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .bus_wdata (bus_wdata),
    .seq_cmd   (seq_cmd),
    .boot_mode (boot_mode),
    .ready     (ready),
    .rpm_en    (rpm_en),
    .flash_rst (flash_rst),
    .area_user (area_user)
);

// File: tb/test_flash_ctl_reg.sv
module test_flash_ctl_reg;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RA = 8'h40;
    localparam logic [7:0] OA = 8'h41;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = RA;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       seq_busy = 1'b0;
    logic [2:0] seq_cmd = 3'd0;
    logic       boot_mode = 1'b0;
    logic       rpm_en, fetch_inhibit, flash_rst, area_user;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_ctl_reg i_flash_ctl_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .seq_busy(seq_busy),
        .seq_cmd(seq_cmd), .boot_mode(boot_mode), .rpm_en(rpm_en),
        .fetch_inhibit(fetch_inhibit), .flash_rst(flash_rst), .area_user(area_user)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a one-clock write; returns just after the following falling edge.
    task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = RA;
        #1;
    endtask

    task automatic read_chk(input string req, input logic [7:0] exp);
        bus_addr = RA; #1;
        check(req, rd_data, exp);
    endtask

    task automatic seq_step(input logic [2:0] c, input logic b);
        seq_cmd = c; seq_busy = b;
        @(negedge clk); #1;
    endtask

    task automatic t_reset;
        read_chk("R8 reset value", 8'h01);
        check("R8 reset outputs", {4'b0, rpm_en, fetch_inhibit, flash_rst, area_user}, 8'h00);
        bus_addr = OA; #1;
        check("R11 other address reads 0", rd_data, 8'h00);
        bus_addr = RA;
    endtask

    task automatic t_single_write;
        bwrite(RA, 8'h02);
        check("R2 single write leaves mode off", {7'b0, rpm_en}, 8'h00);
        bwrite(RA, 8'h0A);
        check("R2 second bit1 write still off", {7'b0, rpm_en}, 8'h00);
    endtask

    task automatic t_arm_and_reset;
        bwrite(RA, 8'h00);
        check("R4 priming write keeps mode off", {7'b0, rpm_en}, 8'h00);
        bwrite(RA, 8'h0A);
        check("R3 arming sets mode", {7'b0, rpm_en}, 8'h01);
        check("R5 fetch inhibit follows mode", {7'b0, fetch_inhibit}, 8'h01);
        check("R6 reset bit ignored on entering write", {7'b0, flash_rst}, 8'h00);
        bwrite(RA, 8'h0A);
        check("R6 reset bit set while mode on", {7'b0, flash_rst}, 8'h01);
        read_chk("R8 readback with mode and reset", 8'h0B);
        bwrite(RA, 8'h08);
        check("R4 clear mode", {7'b0, rpm_en}, 8'h00);
        check("R7 reset cleared with mode", {7'b0, flash_rst}, 8'h00);
        check("R5 fetch inhibit cleared", {7'b0, fetch_inhibit}, 8'h00);
    endtask

    task automatic t_cancel;
        bwrite(RA, 8'h00);
        bwrite(OA, 8'h02);
        bwrite(RA, 8'h02);
        check("R9 foreign write cancels arming", {7'b0, rpm_en}, 8'h00);
        bwrite(RA, 8'h08);
        check("R6 reset write ignored with mode off", {7'b0, flash_rst}, 8'h00);
    endtask

    task automatic t_ready;
        logic [2:0] q [3] = '{3'd1, 3'd2, 3'd3};
        for (int i = 0; i < 3; i++) begin
            seq_step(q[i], 1'b1);
            read_chk($sformatf("R1 busy cmd %0d", q[i]), 8'h00);
            seq_step(3'd4, 1'b0);
            read_chk("R1 other cmd holds busy", 8'h00);
            seq_step(q[i], 1'b0);
            read_chk($sformatf("R1 ready cmd %0d", q[i]), 8'h01);
        end
        seq_step(3'd4, 1'b1);
        read_chk("R1 other cmd ignores busy", 8'h01);
        seq_step(3'd0, 1'b1);
        read_chk("R1 idle cmd ignores busy", 8'h01);
        seq_step(3'd0, 1'b0);
    endtask

    task automatic t_area;
        boot_mode = 1'b1;
        bwrite(RA, 8'h20);
        check("R10 area set in boot mode", {7'b0, area_user}, 8'h01);
        boot_mode = 1'b0;
        bwrite(RA, 8'h00);
        check("R10 area write ignored outside boot", {7'b0, area_user}, 8'h01);
        bwrite(RA, 8'hD4);
        read_chk("R8 unused bits read 0", 8'h21);
        boot_mode = 1'b1;
        bwrite(RA, 8'h00);
        check("R10 area cleared in boot mode", {7'b0, area_user}, 8'h00);
        boot_mode = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        read_chk("R8 value after reset release", 8'h01);
        t_single_write();
        t_arm_and_reset();
        t_cancel();
        t_ready();
        t_area();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule